// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Front End

This block sits behind the serial pins of a flash device and handles one command: erasing the whole array. It samples the data-in line on each rising edge of the serial clock while the chip select is low. It packs the bits into bytes, most significant bit first, and compares the first four bytes of the transaction against a fixed four-byte erase signature. The command takes no address bytes.

When chip select returns high on a byte boundary after a correct signature, a sequencer starts. It visits every sector in index order. Each sector is erased unless its protect flag or its lock flag is set. For each sector that may be erased, the sequencer sends a one-cycle request on a memory-side port and then holds that sector for a parameterized number of clock cycles. A ready flag reads 0 for the whole erase.

The block also keeps the write-protect state. A change on the write-protect pin during an erase is held back and takes effect only once the erase has finished.

Top module: `sfe_chip_erase`

## Requirements
- R1: After reset, `ready` is 1, `erase_req` is 0 and `wp_active` is 0 while `wp` is low.
- R2: The bytes 8'hC7, 8'h94, 8'h80, 8'h9A, sent in that order as the first four bytes after `cs_n` falls, start an erase once `cs_n` rises. Bits are taken MSB first on rising `sck` while `cs_n` is low.
- R3: If any of the first four bytes differs from the signature, no erase starts.
- R4: If `cs_n` rises after fewer than 32 bits, no erase starts.
- R5: If `cs_n` rises when the bit count is not a multiple of 8, no erase starts, even if the first four bytes were correct.
- R6: Whole bytes sent after the fourth signature byte are ignored, and the erase still runs in full.
- R7: No erase starts while `cs_n` stays low, even after the complete signature. `ready` stays 1 until `cs_n` rises.
- R8: During an erase `ready` is 0. Each sector that may be erased gets exactly one `erase_req` pulse, with its index on `erase_sector`. Each such sector is held for at least ERASE_CYCLES cycles before the next request or before `ready` returns to 1.
- R9: A sector whose `sect_protect` or `sect_lock` bit is set when the erase starts never receives a request. If every sector is skipped, the erase ends without any request.
- R10: A command received while an erase is running is ignored. It neither restarts the erase nor starts another one afterwards.
- R11: While idle, `wp_active` follows `wp`. During an erase `wp_active` holds its value, and it takes the value of `wp` after `ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp | input | 1 | Write-protect pin |
| sect_protect | input | SECTORS | Per-sector protect flags |
| sect_lock | input | SECTORS | Per-sector lock flags |
| ready | output | 1 | 1 when idle, 0 while erasing |
| wp_active | output | 1 | Write-protect state in force |
| erase_req | output | 1 | One-cycle erase request to the array |
| erase_sector | output | $clog2(SECTORS) | Sector index for the request |

## Verification
The hardest case to reach is a second, complete and correct command that arrives while an erase is already running. Sending it takes hundreds of cycles, so the bench sets ERASE_CYCLES so that an eight-sector erase outlasts a full 32-bit transfer. It then sends the second signature as soon as `ready` falls. Afterwards it counts every request and confirms that no second busy period follows. The deferred write-protect update is reached the same way: the bench toggles `wp` in the middle of a running erase.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef logic [7:0] byte_t;

    localparam int SIG_LEN = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SCAN,
        SEQ_HOLD
    } seq_state_t;

    function automatic byte_t sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'hC7;
            2'd1:    return 8'h94;
            2'd2:    return 8'h80;
            default: return 8'h9A;
        endcase
    endfunction

endpackage

// File: rtl/sfe_spi_rx.sv
module sfe_spi_rx
    import sfe_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sck,
    input  logic  cs_n,
    input  logic  si,
    output logic  byte_stb,
    output byte_t byte_data,
    output logic  cs_active,
    output logic  cs_rise,
    output logic  at_boundary
);

    logic [SYNC-1:0] sck_s, cs_s, si_s;
    logic            sck_d, cs_d;
    logic [2:0]      bit_cnt;
    logic [6:0]      shreg;
    logic            sck_rise;

    assign sck_rise    = sck_s[SYNC-1] & ~sck_d;
    assign cs_active   = ~cs_s[SYNC-1];
    assign cs_rise     = cs_s[SYNC-1] & ~cs_d;
    assign at_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s     <= '0;
            cs_s      <= '1;
            si_s      <= '0;
            sck_d     <= 1'b0;
            cs_d      <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
        end else begin
            sck_s    <= {sck_s[SYNC-2:0], sck};
            cs_s     <= {cs_s[SYNC-2:0], cs_n};
            si_s     <= {si_s[SYNC-2:0], si};
            sck_d    <= sck_s[SYNC-1];
            cs_d     <= cs_s[SYNC-1];
            byte_stb <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], si_s[SYNC-1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb  <= 1'b1;
                    byte_data <= {shreg, si_s[SYNC-1]};
                end
            end
        end
    end

endmodule

// File: rtl/sfe_sig_match.sv
module sfe_sig_match
    import sfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  byte_stb,
    input  byte_t byte_data,
    input  logic  cs_active,
    input  logic  cs_rise,
    input  logic  at_boundary,
    output logic  start
);

    localparam logic [2:0] FULL = 3'(SIG_LEN);

    logic [2:0] nbytes;
    logic       ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            nbytes <= '0;
            ok     <= 1'b1;
            start  <= 1'b0;
        end else begin
            start <= 1'b0;
            if (cs_rise) begin
                start  <= ok && (nbytes == FULL) && at_boundary;
                nbytes <= '0;
                ok     <= 1'b1;
            end else if (!cs_active) begin
                nbytes <= '0;
                ok     <= 1'b1;
            end else if (byte_stb && nbytes != FULL) begin
                ok     <= ok && (byte_data == sig_byte(nbytes[1:0]));
                nbytes <= nbytes + 3'd1;
            end
        end
    end

    assert_start_on_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(cs_rise));

    assert_start_needs_four_R4: assert property (@(posedge clk) disable iff (rst)
        start |-> ($past(nbytes) == FULL));

endmodule

// File: rtl/sfe_erase_seq.sv
module sfe_erase_seq
    import sfe_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int ERASE_CYCLES = 64,
    localparam int SW          = $clog2(SECTORS),
    localparam int TW          = $clog2(ERASE_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SECTORS-1:0] sect_protect,
    input  logic [SECTORS-1:0] sect_lock,
    input  logic               wp,
    output logic               busy,
    output logic               wp_active,
    output logic               erase_req,
    output logic [SW-1:0]      erase_sector
);

    localparam logic [SW-1:0] LAST  = SW'(SECTORS - 1);
    localparam logic [TW-1:0] HOLDV = TW'(ERASE_CYCLES - 1);

    seq_state_t         state;
    logic [SECTORS-1:0] skip;
    logic [SW-1:0]      sect;
    logic [TW-1:0]      timer;

    assign busy         = (state != SEQ_IDLE);
    assign erase_sector = sect;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            skip      <= '0;
            sect      <= '0;
            timer     <= '0;
            erase_req <= 1'b0;
        end else begin
            erase_req <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        skip  <= sect_protect | sect_lock;
                        sect  <= '0;
                        state <= SEQ_SCAN;
                    end
                end
                SEQ_SCAN: begin
                    if (skip[sect]) begin
                        if (sect == LAST) state <= SEQ_IDLE;
                        else              sect  <= sect + 1'b1;
                    end else begin
                        erase_req <= 1'b1;
                        timer     <= HOLDV;
                        state     <= SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    if (timer == '0) begin
                        if (sect == LAST) begin
                            state <= SEQ_IDLE;
                        end else begin
                            sect  <= sect + 1'b1;
                            state <= SEQ_SCAN;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       wp_active <= 1'b0;
        else if (!busy) wp_active <= wp;
    end

    assert_req_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> busy);

    assert_req_not_skipped_R9: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> !skip[erase_sector]);

    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_wp_held_R11: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(wp_active));

endmodule

// File: rtl/sfe_chip_erase.sv
module sfe_chip_erase
    import sfe_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int SYNC         = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sck,
    input  logic                       cs_n,
    input  logic                       si,
    input  logic                       wp,
    input  logic [SECTORS-1:0]         sect_protect,
    input  logic [SECTORS-1:0]         sect_lock,
    output logic                       ready,
    output logic                       wp_active,
    output logic                       erase_req,
    output logic [$clog2(SECTORS)-1:0] erase_sector
);

    byte_t rx_byte;
    logic  rx_stb, cs_active, cs_rise, at_boundary;
    logic  start, busy;

    sfe_spi_rx #(.SYNC(SYNC)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .sck         (sck),
        .cs_n        (cs_n),
        .si          (si),
        .byte_stb    (rx_stb),
        .byte_data   (rx_byte),
        .cs_active   (cs_active),
        .cs_rise     (cs_rise),
        .at_boundary (at_boundary)
    );

    sfe_sig_match u_match (
        .clk         (clk),
        .rst         (rst),
        .byte_stb    (rx_stb),
        .byte_data   (rx_byte),
        .cs_active   (cs_active),
        .cs_rise     (cs_rise),
        .at_boundary (at_boundary),
        .start       (start)
    );

    sfe_erase_seq #(
        .SECTORS      (SECTORS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sect_protect (sect_protect),
        .sect_lock    (sect_lock),
        .wp           (wp),
        .busy         (busy),
        .wp_active    (wp_active),
        .erase_req    (erase_req),
        .erase_sector (erase_sector)
    );

    assign ready = ~busy;

    assert_no_req_when_ready_R8: assert property (@(posedge clk) disable iff (rst)
        ready |-> !erase_req);

endmodule

// File: tb/sfe_chip_erase_test.sv
module sfe_chip_erase_test;

    localparam int SECTORS = 8;
    localparam int ECYC    = 64;
    localparam int HALF    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp = 1'b0;
    logic [7:0] sect_protect = '0, sect_lock = '0;
    logic       ready, wp_active, erase_req;
    logic [2:0] erase_sector;

    int tests = 0, fails = 0;
    int cyc = 0, reqs = 0, last_req = -1, min_gap = 1 << 30;
    logic [7:0] erased = '0;
    logic       busy_seen = 1'b0, prev_ready = 1'b1;
    bit         done = 1'b0;

    sfe_chip_erase #(.SECTORS(SECTORS), .ERASE_CYCLES(ECYC)) uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp(wp),
        .sect_protect(sect_protect), .sect_lock(sect_lock),
        .ready(ready), .wp_active(wp_active),
        .erase_req(erase_req), .erase_sector(erase_sector)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_ready <= ready;
        if (!ready) busy_seen <= 1'b1;
        if (erase_req) begin
            reqs   <= reqs + 1;
            erased <= erased | (8'd1 << erase_sector);
            if (last_req >= 0 && cyc - last_req < min_gap) min_gap <= cyc - last_req;
            last_req <= cyc;
        end
        if (ready && !prev_ready && last_req >= 0 && cyc - last_req < min_gap)
            min_gap <= cyc - last_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk);
        reqs = 0; erased = '0; busy_seen = 1'b0; last_req = -1; min_gap = 1 << 30;
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si = b[i];
            wclk(HALF);
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_high();
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    task automatic send_sig(input logic [7:0] b2);
        send_bits(8'hC7, 8);
        send_bits(8'h94, 8);
        send_bits(b2, 8);
        send_bits(8'h9A, 8);
    endtask

    task automatic wait_idle();
        int g = 0;
        wclk(12);
        while (!ready && g < 5000) begin
            wclk(1);
            g++;
        end
        wclk(2);
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(erase_req == 1'b0, "R1 erase_req", erase_req, 0);
        chk(wp_active == 1'b0, "R1 wp_active", wp_active, 0);
    endtask

    task automatic t_good();
        clr_mon();
        cs_low();
        send_sig(8'h80);
        wclk(30);
        chk(ready == 1'b1 && !busy_seen, "R7 held cs_n", ready, 1);
        cs_high();
        wait_idle();
        chk(busy_seen, "R2 erase started", busy_seen, 1);
        chk(reqs == SECTORS, "R8 request count", reqs, SECTORS);
        chk(erased == 8'hFF, "R8 sectors erased", erased, 8'hFF);
        chk(min_gap >= ECYC, "R8 per-sector hold", min_gap, ECYC);
        chk(ready == 1'b1, "R8 ready after erase", ready, 1);
    endtask

    task automatic t_bad_byte();
        clr_mon();
        cs_low();
        send_sig(8'h81);
        cs_high();
        wait_idle();
        chk(!busy_seen && reqs == 0, "R3 mismatched byte", reqs, 0);
    endtask

    task automatic t_short();
        clr_mon();
        cs_low();
        send_bits(8'hC7, 8);
        send_bits(8'h94, 8);
        send_bits(8'h80, 8);
        cs_high();
        wait_idle();
        chk(!busy_seen && reqs == 0, "R4 three bytes", reqs, 0);
        clr_mon();
        cs_low();
        send_bits(8'hC7, 8);
        send_bits(8'h94, 8);
        send_bits(8'h80, 8);
        send_bits(8'h9A, 5);
        cs_high();
        wait_idle();
        chk(!busy_seen && reqs == 0, "R4 29 bits", reqs, 0);
    endtask

    task automatic t_unaligned();
        clr_mon();
        cs_low();
        send_sig(8'h80);
        send_bits(8'h00, 4);
        cs_high();
        wait_idle();
        chk(!busy_seen && reqs == 0, "R5 36 bits", reqs, 0);
    endtask

    task automatic t_extra();
        clr_mon();
        cs_low();
        send_sig(8'h80);
        send_bits(8'h00, 8);
        send_bits(8'hFF, 8);
        cs_high();
        wait_idle();
        chk(reqs == SECTORS && erased == 8'hFF, "R6 trailing bytes", erased, 8'hFF);
    endtask

    task automatic t_protect();
        sect_protect = 8'h05;
        sect_lock    = 8'h30;
        clr_mon();
        cs_low();
        send_sig(8'h80);
        cs_high();
        sect_protect = 8'h00;
        sect_lock    = 8'h00;
        wait_idle();
        chk(erased == 8'hCA && reqs == 4, "R9 skipped sectors", erased, 8'hCA);
        sect_protect = 8'hF0;
        sect_lock    = 8'h0F;
        clr_mon();
        cs_low();
        send_sig(8'h80);
        cs_high();
        wait_idle();
        chk(reqs == 0 && ready, "R9 all skipped", reqs, 0);
        sect_protect = 8'h00;
        sect_lock    = 8'h00;
    endtask

    task automatic t_busy_cmd();
        clr_mon();
        cs_low();
        send_sig(8'h80);
        cs_high();
        wclk(10);
        chk(ready == 1'b0, "R10 busy before second cmd", ready, 0);
        cs_low();
        send_sig(8'h80);
        cs_high();
        chk(ready == 1'b0, "R10 still first erase", ready, 0);
        wait_idle();
        wclk(40);
        chk(reqs == SECTORS && ready, "R10 single pass", reqs, SECTORS);
    endtask

    task automatic t_wp();
        wp = 1'b1;
        wclk(4);
        chk(wp_active == 1'b1, "R11 idle follow high", wp_active, 1);
        wp = 1'b0;
        wclk(4);
        chk(wp_active == 1'b0, "R11 idle follow low", wp_active, 0);
        clr_mon();
        cs_low();
        send_sig(8'h80);
        cs_high();
        wclk(20);
        wp = 1'b1;
        wclk(100);
        chk(wp_active == 1'b0 && !ready, "R11 deferred", wp_active, 0);
        wait_idle();
        chk(wp_active == 1'b1, "R11 applied at end", wp_active, 1);
        wp = 1'b0;
        wclk(4);
    endtask

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(3);
        t_reset();
        t_good();
        t_bad_byte();
        t_short();
        t_unaligned();
        t_extra();
        t_protect();
        t_busy_cmd();
        t_wp();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule